// File: doc/BRIEF.md
# System Control Coprocessor Register File

This block holds the control and status registers of a processor's system-control coprocessor. Registers are addressed by a 5-bit register number and a 3-bit select. Writes come through a single move-to port. Each register has its own pair of masks. Bits under the write mask take the new data. Bits under the keep mask hold their old value. All other bits read as zero. Reads come through a move-from port and are combinational from the stored state.

Some writes have side effects. A Status write copies three of its bits into the live mode flags: user, error level and exception level. A Status write that re-enables interrupts while an unmasked interrupt is pending raises an interrupt request. An address-space identifier change in EntryHi requests a flush of the translation cache. A Debug write drives the debug-mode flag.

Three things stay outside the block and reach it through ports: the timer, the translation table and the load-linked unit. The block therefore only reflects their values. There is no state machine here: every register updates in a single cycle. The only sequencing is the one-cycle pulse on the interrupt and flush outputs.

Top module: `cop0_regfile`

## Requirements
- R1: After reset every register reads zero, except Status, which reads 0x00000004 because the error-level flag resets to 1. All outputs are low except `mode_erl`.
- R2: A write of value D to a register with keep mask K and write mask W leaves (old & K) | (D & W). The masks are listed below.
  - Index (0): K=0x80000000, W=0x0000000F.
  - EntryLo0/1 (2, 3): W=0x3FFFFFFF.
  - Context (4): K=0xFF000000, W=0x00FFFFF0.
  - PageMask (5): W=0x01FFE000.
  - Wired (6): W=0x0000000F.
  - EntryHi (10): W=0xFFFFF0FF.
  - Compare (11), EPC (14), WatchLo (18), DEPC (24), ErrorEPC (30), DESAVE (31): W=0xFFFFFFFF.
  - Config0 (16): K=0xFE17FF80, W=0x00000001.
  - WatchHi (19): W=0x40FF0FF8.
  - TagLo (28): W=0xFFFFFCF6.
  - Status (12): W=0xFA78FF01.
  - Cause (13): K=0xB000F87C, W=0x00C00300.
  - Debug (23): K=0x8C03FC1F, W=0x13300120.
  - Any other register number: no bits are stored, and the register reads zero.
- R3: A select of 1 is legal only for register 16, where it reads the constant `CFG1_VALUE` and ignores writes, and for register 28, where it is a full 32-bit data register. Any other non-zero select reads zero and its writes change nothing.
- R4: A write to EntryHi whose bits 7:0 differ from the stored bits 7:0 makes `tlb_flush` high for exactly the one cycle after the write edge. A write that leaves bits 7:0 unchanged does not.
- R5: A Status write sets `mode_user`, `mode_erl` and `mode_exl` from data bits 4, 2 and 1. A Status read returns the stored value ORed with those flags at bits 4, 2 and 1.
- R6: A Status write raises `irq_raise` for one cycle when all of the following hold:
  - bit 0 goes from 0 to 1;
  - data bits 1 and 2 are clear;
  - `mode_dbg` is clear;
  - (new Status & current Cause & 0x0000FF00) is non-zero.
- R7: `irq_pend` is set together with `irq_raise`. It is cleared by a Status write that takes bit 0 from 1 to 0.
- R8: A Debug write sets `mode_dbg` from data bit 30. A Debug read ORs `mode_dbg` into bit 30.
- R9: Cause bits 15:10 follow `hw_irq` with one cycle of delay, whatever is written to them.
- R10: A cycle with `ll_set` high stores `ll_addr`. Register 17 reads that stored address shifted right by 4.
- R11: Register 1 reads `random_in` and register 9 reads `count_in`. Writes to either change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Move-to write strobe |
| wr_num | input | 5 | Write register number |
| wr_sel | input | 3 | Write select |
| wr_data | input | 32 | Write data |
| rd_num | input | 5 | Read register number |
| rd_sel | input | 3 | Read select |
| rd_data | output | 32 | Read data, combinational |
| hw_irq | input | 6 | Hardware interrupt lines into Cause 15:10 |
| random_in | input | 32 | Replacement index from the translation unit |
| count_in | input | 32 | Live timer value |
| ll_set | input | 1 | Load-linked address capture strobe |
| ll_addr | input | 32 | Load-linked address |
| irq_raise | output | 1 | One-cycle interrupt request pulse |
| irq_pend | output | 1 | Hard-interrupt request level |
| tlb_flush | output | 1 | One-cycle translation flush pulse |
| mode_user | output | 1 | User-mode flag |
| mode_erl | output | 1 | Error-level flag |
| mode_exl | output | 1 | Exception-level flag |
| mode_dbg | output | 1 | Debug-mode flag |

## Verification
Two functions can meet in the same clock edge: a Status write that re-enables interrupts, and a hardware line entering Cause bits 15:10. The bench provokes this by raising `hw_irq` in the very cycle of a Status write that sets IE with a matching mask bit. It expects no `irq_raise`, because the check sees the Cause value registered before that edge. It then shows that the line does appear in Cause one cycle later. The converse case is also checked: the line is raised first, and the same Status write then does raise the request.

// File: rtl/cop0_pkg.sv
package cop0_pkg;
    localparam int DATA_W  = 32;
    localparam int NUM_W   = 5;
    localparam int SEL_W   = 3;
    localparam int NREGS   = 1 << NUM_W;
    localparam int IRQ_W   = 6;
    localparam int IRQ_LSB = 10;

    localparam int ST_IE  = 0;
    localparam int ST_EXL = 1;
    localparam int ST_ERL = 2;
    localparam int ST_UM  = 4;
    localparam int DB_DM  = 30;
    localparam int LL_SHIFT = 4;
    localparam logic [DATA_W-1:0] IM_FIELD = 32'h0000_FF00;

    localparam logic [NUM_W-1:0] RN_RANDOM = 5'd1;
    localparam logic [NUM_W-1:0] RN_COUNT  = 5'd9;
    localparam logic [NUM_W-1:0] RN_ASIDHI = 5'd10;
    localparam logic [NUM_W-1:0] RN_STAT   = 5'd12;
    localparam logic [NUM_W-1:0] RN_CAUSE  = 5'd13;
    localparam logic [NUM_W-1:0] RN_CFG    = 5'd16;
    localparam logic [NUM_W-1:0] RN_LLA    = 5'd17;
    localparam logic [NUM_W-1:0] RN_DBG    = 5'd23;
    localparam logic [NUM_W-1:0] RN_TAG    = 5'd28;

    typedef struct packed {
        logic [DATA_W-1:0] keep;
        logic [DATA_W-1:0] wr;
    } mask_t;

    function automatic mask_t reg_mask(input logic [NUM_W-1:0] num);
        mask_t m;
        m.keep = '0;
        m.wr   = '0;
        case (num)
            5'd0:  begin m.keep = 32'h8000_0000; m.wr = 32'h0000_000F; end
            5'd2,
            5'd3:  m.wr = 32'h3FFF_FFFF;
            5'd4:  begin m.keep = 32'hFF00_0000; m.wr = 32'h00FF_FFF0; end
            5'd5:  m.wr = 32'h01FF_E000;
            5'd6:  m.wr = 32'h0000_000F;
            5'd10: m.wr = 32'hFFFF_F0FF;
            5'd11, 5'd14, 5'd18, 5'd24, 5'd30, 5'd31:
                   m.wr = 32'hFFFF_FFFF;
            5'd12: m.wr = 32'hFA78_FF01;
            5'd13: begin m.keep = 32'hB000_F87C; m.wr = 32'h00C0_0300; end
            5'd16: begin m.keep = 32'hFE17_FF80; m.wr = 32'h0000_0001; end
            5'd19: m.wr = 32'h40FF_0FF8;
            5'd23: begin m.keep = 32'h8C03_FC1F; m.wr = 32'h1330_0120; end
            5'd28: m.wr = 32'hFFFF_FCF6;
            default: ;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/cop0_addr_dec.sv
module cop0_addr_dec
    import cop0_pkg::*;
(
    input  logic [NUM_W-1:0] num,
    input  logic [SEL_W-1:0] sel,
    output logic             legal,
    output logic             alt
);
    logic alt_num;

    always_comb begin
        alt_num = (num == RN_CFG) || (num == RN_TAG);
        alt     = alt_num && (sel == SEL_W'(1));
        legal   = (sel == '0) || alt;
    end
endmodule

// File: rtl/cop0_wr_merge.sv
module cop0_wr_merge
    import cop0_pkg::*;
(
    input  logic [NUM_W-1:0]  num,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] new_data,
    output logic [DATA_W-1:0] merged
);
    mask_t m;

    always_comb begin
        m      = reg_mask(num);
        merged = (old_val & m.keep) | (new_data & m.wr);
    end
endmodule

// File: rtl/cop0_event_unit.sv
module cop0_event_unit
    import cop0_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_wr,
    input  logic              eh_wr,
    input  logic              dbg_wr,
    input  logic [DATA_W-1:0] st_old,
    input  logic [DATA_W-1:0] st_new,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cause_q,
    input  logic [7:0]        asid_old,
    input  logic [7:0]        asid_new,
    output logic              irq_raise,
    output logic              irq_pend,
    output logic              tlb_flush,
    output logic              mode_user,
    output logic              mode_erl,
    output logic              mode_exl,
    output logic              mode_dbg
);
    logic raise_d;
    logic drop_d;
    logic flush_d;

    always_comb begin
        raise_d = st_wr && st_new[ST_IE] && !st_old[ST_IE]
                  && !wdata[ST_EXL] && !wdata[ST_ERL] && !mode_dbg
                  && |(st_new & cause_q & IM_FIELD);
        drop_d  = st_wr && !st_new[ST_IE] && st_old[ST_IE];
        flush_d = eh_wr && (asid_old != asid_new);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_raise <= 1'b0;
            irq_pend  <= 1'b0;
            tlb_flush <= 1'b0;
            mode_user <= 1'b0;
            mode_erl  <= 1'b1;
            mode_exl  <= 1'b0;
            mode_dbg  <= 1'b0;
        end else begin
            irq_raise <= raise_d;
            tlb_flush <= flush_d;
            if (raise_d)
                irq_pend <= 1'b1;
            else if (drop_d)
                irq_pend <= 1'b0;
            if (st_wr) begin
                mode_user <= wdata[ST_UM];
                mode_erl  <= wdata[ST_ERL];
                mode_exl  <= wdata[ST_EXL];
            end
            if (dbg_wr)
                mode_dbg <= wdata[DB_DM];
        end
    end
endmodule

// File: rtl/cop0_regfile.sv
module cop0_regfile
    import cop0_pkg::*;
#(
    parameter logic [31:0] CFG1_VALUE = 32'h1E19_0C8A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [4:0]  wr_num,
    input  logic [2:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [4:0]  rd_num,
    input  logic [2:0]  rd_sel,
    output logic [31:0] rd_data,
    input  logic [5:0]  hw_irq,
    input  logic [31:0] random_in,
    input  logic [31:0] count_in,
    input  logic        ll_set,
    input  logic [31:0] ll_addr,
    output logic        irq_raise,
    output logic        irq_pend,
    output logic        tlb_flush,
    output logic        mode_user,
    output logic        mode_erl,
    output logic        mode_exl,
    output logic        mode_dbg
);
    logic [DATA_W-1:0] regs [NREGS];
    logic [DATA_W-1:0] datalo_q;

    logic              wr_legal, wr_alt, rd_legal, rd_alt;
    logic              wr_main;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] cause_base;
    logic [DATA_W-1:0] cause_next;
    logic              st_wr, eh_wr, dbg_wr;

    cop0_addr_dec u_wdec (.num(wr_num), .sel(wr_sel), .legal(wr_legal), .alt(wr_alt));
    cop0_addr_dec u_rdec (.num(rd_num), .sel(rd_sel), .legal(rd_legal), .alt(rd_alt));

    cop0_wr_merge u_merge (
        .num      (wr_num),
        .old_val  (regs[wr_num]),
        .new_data (wr_data),
        .merged   (merged)
    );

    always_comb begin
        wr_main = wr_en && wr_legal && !wr_alt;
        st_wr   = wr_main && (wr_num == RN_STAT);
        eh_wr   = wr_main && (wr_num == RN_ASIDHI);
        dbg_wr  = wr_main && (wr_num == RN_DBG);
        cause_base = (wr_main && (wr_num == RN_CAUSE)) ? merged : regs[RN_CAUSE];
        cause_next = cause_base;
        cause_next[IRQ_LSB +: IRQ_W] = hw_irq;
    end

    // One storage word per register number; special words get their own source.
    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        if (i == int'(RN_CAUSE)) begin : g_cause
            always_ff @(posedge clk) begin
                if (!rst_n) regs[i] <= '0;
                else        regs[i] <= cause_next;
            end
        end else if (i == int'(RN_LLA)) begin : g_ll
            always_ff @(posedge clk) begin
                if (!rst_n)      regs[i] <= '0;
                else if (ll_set) regs[i] <= ll_addr;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[i] <= '0;
                else if (wr_main && (wr_num == NUM_W'(i)))
                    regs[i] <= merged;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            datalo_q <= '0;
        else if (wr_en && wr_alt && (wr_num == RN_TAG))
            datalo_q <= wr_data;
    end

    cop0_event_unit u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_wr     (st_wr),
        .eh_wr     (eh_wr),
        .dbg_wr    (dbg_wr),
        .st_old    (regs[RN_STAT]),
        .st_new    (merged),
        .wdata     (wr_data),
        .cause_q   (regs[RN_CAUSE]),
        .asid_old  (regs[RN_ASIDHI][7:0]),
        .asid_new  (merged[7:0]),
        .irq_raise (irq_raise),
        .irq_pend  (irq_pend),
        .tlb_flush (tlb_flush),
        .mode_user (mode_user),
        .mode_erl  (mode_erl),
        .mode_exl  (mode_exl),
        .mode_dbg  (mode_dbg)
    );

    always_comb begin
        rd_data = '0;
        if (rd_legal) begin
            if (rd_alt) begin
                rd_data = (rd_num == RN_CFG) ? CFG1_VALUE : datalo_q;
            end else begin
                unique case (rd_num)
                    RN_RANDOM: rd_data = random_in;
                    RN_COUNT:  rd_data = count_in;
                    RN_STAT: begin
                        rd_data = regs[RN_STAT];
                        rd_data[ST_UM]  = rd_data[ST_UM]  | mode_user;
                        rd_data[ST_ERL] = rd_data[ST_ERL] | mode_erl;
                        rd_data[ST_EXL] = rd_data[ST_EXL] | mode_exl;
                    end
                    RN_LLA:    rd_data = regs[RN_LLA] >> LL_SHIFT;
                    RN_DBG: begin
                        rd_data = regs[RN_DBG];
                        rd_data[DB_DM] = rd_data[DB_DM] | mode_dbg;
                    end
                    default:   rd_data = regs[rd_num];
                endcase
            end
        end
    end
endmodule

// File: rtl/cop0_regfile_chk.sv
module cop0_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [4:0]  wr_num,
    input logic [2:0]  wr_sel,
    input logic [31:0] wr_data,
    input logic [4:0]  rd_num,
    input logic [2:0]  rd_sel,
    input logic [31:0] rd_data,
    input logic [31:0] index_q,
    input logic        irq_raise,
    input logic        irq_pend,
    input logic        tlb_flush,
    input logic        mode_user,
    input logic        mode_erl,
    input logic        mode_exl,
    input logic        mode_dbg
);
    logic st_w, eh_w, db_w, ix_w;

    always_comb begin
        st_w = wr_en && (wr_sel == 3'd0) && (wr_num == 5'd12);
        eh_w = wr_en && (wr_sel == 3'd0) && (wr_num == 5'd10);
        db_w = wr_en && (wr_sel == 3'd0) && (wr_num == 5'd23);
        ix_w = wr_en && (wr_sel == 3'd0) && (wr_num == 5'd0);
    end

    a_r2_index_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ix_w |=> (index_q[31] == $past(index_q[31])));

    a_r3_bad_select_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_sel != 3'd0) && (rd_num != 5'd16) && (rd_num != 5'd28)) |-> (rd_data == 32'd0));

    a_r4_flush_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush |-> $past(eh_w));

    a_r5_modes_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !st_w |=> $stable({mode_user, mode_erl, mode_exl}));

    a_r6_raise_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq_raise |-> ($past(st_w) && irq_pend));

    a_r7_pend_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_pend) |-> $past(st_w && !wr_data[0]));

    a_r8_dbg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !db_w |=> $stable(mode_dbg));
endmodule

bind cop0_regfile cop0_regfile_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_num    (wr_num),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .rd_num    (rd_num),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data),
    .index_q   (regs[0]),
    .irq_raise (irq_raise),
    .irq_pend  (irq_pend),
    .tlb_flush (tlb_flush),
    .mode_user (mode_user),
    .mode_erl  (mode_erl),
    .mode_exl  (mode_exl),
    .mode_dbg  (mode_dbg)
);

// File: tb/sim_cop0_regfile.sv
module sim_cop0_regfile;
    localparam int PERIOD = 10;
    localparam logic [31:0] CFG1 = 32'h1E19_0C8A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_num = '0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_num = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic [5:0]  hw_irq = '0;
    logic [31:0] random_in = '0;
    logic [31:0] count_in = '0;
    logic        ll_set = 1'b0;
    logic [31:0] ll_addr = '0;
    logic        irq_raise, irq_pend, tlb_flush;
    logic        mode_user, mode_erl, mode_exl, mode_dbg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    cop0_regfile #(.CFG1_VALUE(CFG1)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_num(wr_num), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_num(rd_num), .rd_sel(rd_sel), .rd_data(rd_data),
        .hw_irq(hw_irq), .random_in(random_in), .count_in(count_in),
        .ll_set(ll_set), .ll_addr(ll_addr), .irq_raise(irq_raise), .irq_pend(irq_pend),
        .tlb_flush(tlb_flush), .mode_user(mode_user), .mode_erl(mode_erl),
        .mode_exl(mode_exl), .mode_dbg(mode_dbg)
    );

    function automatic logic [31:0] wmask(input int n);
        case (n)
            0, 6:                    return 32'h0000_000F;
            2, 3:                    return 32'h3FFF_FFFF;
            4:                       return 32'h00FF_FFF0;
            5:                       return 32'h01FF_E000;
            10:                      return 32'hFFFF_F0FF;
            11, 14, 18, 24, 30, 31:  return 32'hFFFF_FFFF;
            16:                      return 32'h0000_0001;
            19:                      return 32'h40FF_0FF8;
            28:                      return 32'hFFFF_FCF6;
            default:                 return 32'h0;
        endcase
    endfunction

    function automatic bit special(input int n);
        return (n == 1) || (n == 9) || (n == 12) || (n == 13) || (n == 17) || (n == 23);
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic do_write(input int n, input int s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_num = 5'(n); wr_sel = 3'(s); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input int n, input int s, output logic [31:0] v);
        rd_num = 5'(n); rd_sel = 3'(s);
        #1;
        v = rd_data;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got %08h expected %08h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();

        // R1 reset state
        for (int n = 0; n < 32; n++) begin
            if (n != 1 && n != 9) begin
                do_read(n, 0, v);
                chk("R1 reset read", v, (n == 12) ? 32'h4 : 32'h0);
            end
        end
        chk("R1 reset flags", {28'd0, mode_user, mode_erl, mode_exl, mode_dbg}, 32'h4);
        chk("R1 reset pulses", {29'd0, irq_raise, irq_pend, tlb_flush}, 32'h0);

        // R3 non-zero selects: writes ignored, reads zero except the two legal ones
        for (int n = 0; n < 32; n++) begin
            for (int s = 1; s < 8; s++) begin
                do_write(n, s, 32'hFFFF_FFFF);
                do_read(n, s, v);
                if (n == 16 && s == 1)      chk("R3 config sel1", v, CFG1);
                else if (n == 28 && s == 1) chk("R3 data sel1", v, 32'hFFFF_FFFF);
                else                        chk("R3 bad select read", v, 32'h0);
            end
            if (n != 1 && n != 9) begin
                do_read(n, 0, v);
                chk("R3 sel0 untouched", v, (n == 12) ? 32'h4 : 32'h0);
            end
        end
        chk("R3 flags untouched", {28'd0, mode_user, mode_erl, mode_exl, mode_dbg}, 32'h4);

        // R2 mask sweep over ordinary registers
        for (int n = 0; n < 32; n++) begin
            if (!special(n)) begin
                do_write(n, 0, 32'hFFFF_FFFF);
                do_read(n, 0, v);
                chk("R2 ones masked", v, wmask(n));
                do_write(n, 0, 32'hA5A5_5A5A);
                do_read(n, 0, v);
                chk("R2 pattern masked", v, 32'hA5A5_5A5A & wmask(n));
                do_write(n, 0, 32'h0);
                do_read(n, 0, v);
                chk("R2 zero", v, 32'h0);
            end
        end
        do_read(28, 1, v);
        chk("R3 data sel1 separate", v, 32'hFFFF_FFFF);

        // R4 flush on ASID change (EntryHi now 0)
        do_write(10, 0, 32'h0000_0012);
        chk("R4 flush pulse", {31'd0, tlb_flush}, 32'h1);
        idle();
        chk("R4 flush one cycle", {31'd0, tlb_flush}, 32'h0);
        do_write(10, 0, 32'h0000_2F12);
        chk("R4 same ASID no flush", {31'd0, tlb_flush}, 32'h0);
        do_read(10, 0, v);
        chk("R4 EntryHi masked", v, 32'h0000_2012);
        do_write(10, 0, 32'h0000_2013);
        chk("R4 ASID bit0 flush", {31'd0, tlb_flush}, 32'h1);

        // R9 hardware lines into Cause
        hw_irq = 6'b101010;
        idle();
        do_read(13, 0, v);
        chk("R9 cause hw bits", v, 32'h0000_A800);
        do_write(13, 0, 32'hFFFF_FFFF);
        do_read(13, 0, v);
        chk("R2 cause masked write", v, 32'h00C0_AB00);
        hw_irq = 6'b000000;
        do_write(13, 0, 32'h0000_FC00);
        do_read(13, 0, v);
        chk("R9 cause hw not writable", v, 32'h0);

        // R5 mode flags through Status
        hw_irq = 6'b000001;
        idle();
        do_write(12, 0, 32'h0000_0017);
        do_read(12, 0, v);
        chk("R5 status read with flags", v, 32'h0000_0017);
        chk("R5 flags set", {28'd0, mode_user, mode_erl, mode_exl, mode_dbg}, 32'hE);
        chk("R6 no raise under error level", {31'd0, irq_raise}, 32'h0);
        do_write(12, 0, 32'h0);
        do_read(12, 0, v);
        chk("R5 status cleared", v, 32'h0);
        chk("R5 flags cleared", {28'd0, mode_user, mode_erl, mode_exl, mode_dbg}, 32'h0);

        // R6/R7 raise and clear
        do_write(12, 0, 32'h0000_0401);
        chk("R6 raise", {31'd0, irq_raise}, 32'h1);
        chk("R7 pend set", {31'd0, irq_pend}, 32'h1);
        idle();
        chk("R6 raise one cycle", {31'd0, irq_raise}, 32'h0);
        chk("R7 pend held", {31'd0, irq_pend}, 32'h1);
        do_write(12, 0, 32'h0000_0401);
        chk("R6 no raise when IE already set", {31'd0, irq_raise}, 32'h0);
        do_write(12, 0, 32'h0000_0400);
        chk("R7 pend cleared", {31'd0, irq_pend}, 32'h0);
        do_write(12, 0, 32'h0000_0403);
        chk("R6 no raise under exception level", {31'd0, irq_raise}, 32'h0);
        do_write(12, 0, 32'h0000_0400);
        do_write(12, 0, 32'h0000_0001);
        chk("R6 no raise when masked", {31'd0, irq_raise}, 32'h0);
        do_write(12, 0, 32'h0000_0000);

        // R6 same-cycle hardware line and Status write
        hw_irq = 6'b000000;
        idle();
        @(negedge clk);
        wr_en = 1'b1; wr_num = 5'd12; wr_sel = 3'd0; wr_data = 32'h0000_0401;
        hw_irq = 6'b000001;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R6 same-cycle line no raise", {31'd0, irq_raise}, 32'h0);
        do_read(13, 0, v);
        chk("R9 line arrives next cycle", v, 32'h0000_0400);
        do_write(12, 0, 32'h0);

        // R8 debug mode
        do_write(23, 0, 32'h4000_0000);
        chk("R8 dbg flag set", {31'd0, mode_dbg}, 32'h1);
        do_write(12, 0, 32'h0000_0401);
        chk("R6 no raise in debug mode", {31'd0, irq_raise}, 32'h0);
        do_write(12, 0, 32'h0);
        do_write(23, 0, 32'hFFFF_FFFF);
        do_read(23, 0, v);
        chk("R8 debug read", v, 32'h5330_0120);
        do_write(23, 0, 32'h0);
        do_read(23, 0, v);
        chk("R8 debug cleared", v, 32'h0);
        chk("R8 dbg flag clear", {31'd0, mode_dbg}, 32'h0);

        // R10 load-linked address
        @(negedge clk);
        ll_set = 1'b1; ll_addr = 32'h1234_5678;
        @(negedge clk);
        ll_set = 1'b0; ll_addr = 32'hFFFF_FFFF;
        do_read(17, 0, v);
        chk("R10 ll shifted", v, 32'h0123_4567);
        do_write(17, 0, 32'hFFFF_FFFF);
        do_read(17, 0, v);
        chk("R10 ll not writable", v, 32'h0123_4567);

        // R11 external views
        random_in = 32'h0000_000B;
        count_in  = 32'hDEAD_BEEF;
        do_read(1, 0, v);
        chk("R11 random", v, 32'h0000_000B);
        do_write(9, 0, 32'h0);
        do_read(9, 0, v);
        chk("R11 count", v, 32'hDEAD_BEEF);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule